// File: doc/BRIEF.md
# Successive Approximation Capacitance Converter Controller

This block runs the binary search of a capacitance-to-digital converter. It produces the digital setting of a programmable reference capacitor array. The array has a coarse section, driven by the upper bits of the code, and a fine section whose range overlaps one coarse step. Each bit trial uses one period of the conversion clock. While the clock is high the sensor is precharged. While it is low the charge amplifier and the comparator evaluate the reference against the sensor. The comparator bit is valid late in the low phase, and the controller samples it at the next rising edge.

A one-cycle start pulse begins a conversion. Trials run from the most significant bit down to the least significant bit. When the last decision is made, the block latches the final code into a result register and raises a done flag for one cycle. The analog parts, namely the op-amp, the comparator and the capacitor array, are outside this block.

Top module: `sar_cap_converter`

## Requirements
- R1: While reset is held and just after it, coarseCode, fineCode and resultCode are all zero and convDone is 0.
- R2: A start pulse sampled while idle clears the search code and sets only the most significant trial bit (bit 12) at the same rising edge. This gives coarseCode = 4'b1000 and fineCode = 0.
- R3: At each rising edge during a search, the bit under trial is kept when cmpBit is 1 (reference smaller than sensor) and cleared when cmpBit is 0. At the same edge the next lower bit is set for trial, and the bits above the trial bit do not change.
- R4: Trials go strictly from bit 12 down to bit 0, one bit per clock period, so one conversion takes 13 periods.
- R5: convDone is 1 for exactly one cycle. It rises on the 13th rising edge after the edge that accepted the start, and resultCode then equals the final search code.
- R6: resultCode changes only at the edge that raises convDone, and otherwise holds its value through any later start and search.
- R7: A start pulse that arrives while a search is running is ignored. The running search keeps its sequence and its finishing time.
- R8: coarseCode is bits 12..9 of the search code, which select the coarse array. fineCode is bits 8..0, which select the fine array.
- R9: If the comparator reports 1 exactly when the applied code is below a sensor value S, the result is S-1 for 1 <= S <= 8192 and 0 for S = 0.
- R10: While idle, cmpBit has no effect: the search code and resultCode stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; high = precharge, low = evaluate |
| rst_n | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request to begin a conversion |
| cmpBit | input | 1 | Comparator decision, 1 = reference below sensor |
| coarseCode | output | 4 | Coarse array selection (code bits 12..9) |
| fineCode | output | 9 | Fine array selection (code bits 8..0) |
| resultCode | output | 13 | Last completed conversion result |
| convDone | output | 1 | One-cycle pulse when a result is latched |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running search. A correct design must leave both the search sequence and the finishing cycle untouched. The bench fires a second start part-way through a conversion and measures the cycle count until convDone. A reference model runs in step with the design and confirms that the code path is unchanged. The comparator is normally a behavioural model that compares against a target. It can be forced to a fixed level, which covers the all-keep and all-clear search paths and also shows that the comparator is ignored while idle.

// File: rtl/sarcdc_pkg.sv
package sarcdc_pkg;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_SEARCH = 1'b1
  } searchPhase_t;

  typedef struct packed {
    logic clearCode;  // start accepted: load MSB-only trial code
    logic decide;     // resolve current trial bit, arm the next
    logic finish;     // this decision is the LSB: latch result
  } ctrlStrobes_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sarcdc_pkg::*;
#(
  parameter int CODE_W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startPulse,
  output ctrlStrobes_t strobes,
  output logic         convDone
);

  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

  searchPhase_t phaseQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic lastTrial;

  assign lastTrial = (bitIdxQ == '0);

  always_comb begin
    strobes = '0;
    if (phaseQ == PH_IDLE) begin
      strobes.clearCode = startPulse;
    end else begin
      strobes.decide = 1'b1;
      strobes.finish = lastTrial;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ  <= PH_IDLE;
      bitIdxQ <= '0;
    end else if (strobes.clearCode) begin
      phaseQ  <= PH_SEARCH;
      bitIdxQ <= TOP_IDX;
    end else if (phaseQ == PH_SEARCH) begin
      if (lastTrial) begin
        phaseQ <= PH_IDLE;
      end else begin
        bitIdxQ <= bitIdxQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convDone <= 1'b0;
    end else begin
      convDone <= strobes.finish;
    end
  end

  // R4
  trial_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseQ == PH_SEARCH && !lastTrial) |=>
      (phaseQ == PH_SEARCH && bitIdxQ == $past(bitIdxQ) - 1'b1));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseQ == PH_SEARCH && startPulse && !lastTrial) |=>
      (bitIdxQ != TOP_IDX));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convDone |=> !convDone);

  // R5
  done_after_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseQ == PH_SEARCH && lastTrial) |=> (convDone && phaseQ == PH_IDLE));

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sarcdc_pkg::*;
#(
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctrlStrobes_t                 strobes,
  input  logic                         cmpBit,
  output logic [COARSE_W-1:0]          coarseCode,
  output logic [FINE_W-1:0]            fineCode,
  output logic [COARSE_W+FINE_W-1:0]   resultCode
);

  localparam int CODE_W = COARSE_W + FINE_W;
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] maskQ;
  logic [CODE_W-1:0] nextMask;
  logic [CODE_W-1:0] decidedCode;
  logic [CODE_W-1:0] resultQ;

  assign nextMask = maskQ >> 1;

  // Per-bit trial cells: the bit under trial takes the comparator decision,
  // the next lower bit is armed, every other bit keeps its value.
  for (genvar i = 0; i < CODE_W; i++) begin : g_bitCell
    assign decidedCode[i] = maskQ[i] ? cmpBit : codeQ[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codeQ[i] <= 1'b0;
      end else if (strobes.clearCode) begin
        codeQ[i] <= MSB_ONLY[i];
      end else if (strobes.decide) begin
        codeQ[i] <= decidedCode[i] | nextMask[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskQ <= '0;
    end else if (strobes.clearCode) begin
      maskQ <= MSB_ONLY;
    end else if (strobes.decide) begin
      maskQ <= nextMask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultQ <= '0;
    end else if (strobes.finish) begin
      resultQ <= decidedCode;
    end
  end

  assign coarseCode = codeQ[CODE_W-1 -: COARSE_W];
  assign fineCode   = codeQ[FINE_W-1:0];
  assign resultCode = resultQ;

  // R2
  start_loads_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearCode |=> (codeQ == MSB_ONLY));

  // R4
  single_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(maskQ));

  // R5
  finish_on_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.finish |-> maskQ[0]);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.finish |=> $stable(resultQ));

  // R10
  idle_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.clearCode && !strobes.decide) |=> $stable(codeQ));

endmodule

// File: rtl/sar_cap_converter.sv
module sar_cap_converter
  import sarcdc_pkg::*;
#(
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        startPulse,
  input  logic                        cmpBit,
  output logic [COARSE_W-1:0]         coarseCode,
  output logic [FINE_W-1:0]           fineCode,
  output logic [COARSE_W+FINE_W-1:0]  resultCode,
  output logic                        convDone
);

  localparam int CODE_W = COARSE_W + FINE_W;

  ctrlStrobes_t strobes;

  sar_ctrl #(
    .CODE_W (CODE_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .strobes    (strobes),
    .convDone   (convDone)
  );

  sar_datapath #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .cmpBit     (cmpBit),
    .coarseCode (coarseCode),
    .fineCode   (fineCode),
    .resultCode (resultCode)
  );

  // R8
  split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convDone |-> ({coarseCode, fineCode} == resultCode));

endmodule

// File: tb/test_sar_cap_converter.sv
module test_sar_cap_converter;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startPulse = 1'b0;
  logic cmpBit;
  logic [3:0]  coarseCode;
  logic [8:0]  fineCode;
  logic [12:0] resultCode;
  logic convDone;

  int target = 0;
  logic cmpForce = 1'b0;
  logic cmpForceVal = 1'b0;
  logic cmpEn = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int  mCode = 0;
  int  mIdx = 0;
  bit  mBusy = 0;
  int  mResult = 0;
  bit  mDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural stand-in for charge amplifier + comparator
  assign cmpBit = cmpForce ? cmpForceVal : (int'({coarseCode, fineCode}) < target);

  sar_cap_converter i_sar_cap_converter (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .cmpBit     (cmpBit),
    .coarseCode (coarseCode),
    .fineCode   (fineCode),
    .resultCode (resultCode),
    .convDone   (convDone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, stepped on the same edge as the design
  always @(posedge clk) begin
    bit c;
    if (!rst_n) begin
      mCode = 0; mIdx = 0; mBusy = 0; mResult = 0; mDone = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        c = cmpForce ? cmpForceVal : (mCode < target);
        if (!c) mCode = mCode & ~(1 << mIdx);
        if (mIdx == 0) begin
          mBusy = 0; mResult = mCode; mDone = 1;
        end else begin
          mIdx = mIdx - 1;
          mCode = mCode | (1 << mIdx);
        end
      end else if (startPulse) begin
        mCode = 1 << 12; mIdx = 12; mBusy = 1;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmpEn) begin
      chk("R4 search code", int'({coarseCode, fineCode}), mCode);
      chk("R5 done flag", int'(convDone), int'(mDone));
      chk("R6 result", int'(resultCode), mResult);
    end
  end

  task automatic startConv(input int tgt, output int cyclesToDone);
    int k;
    target = tgt;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    // R2: MSB-only trial right after the accepting edge
    chk("R2 coarse after start", int'(coarseCode), 8);
    chk("R2 fine after start", int'(fineCode), 0);
    k = 0;
    while (!convDone && k < 40) begin
      @(negedge clk);
      k++;
    end
    cyclesToDone = k;
  endtask

  function automatic int expectResult(input int s);
    if (s <= 0) return 0;
    if (s > 8192) return 8191;
    return s - 1;
  endfunction

  initial begin
    int cyc;
    int saveCode;
    int saveRes;
    int tgts[6] = '{0, 1, 8192, 4096, 2731, 5000};
    @(negedge clk);
    // R1: during reset
    chk("R1 coarse in reset", int'(coarseCode), 0);
    chk("R1 fine in reset", int'(fineCode), 0);
    chk("R1 result in reset", int'(resultCode), 0);
    chk("R1 done in reset", int'(convDone), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cmpEn = 1'b1;
    @(negedge clk);
    chk("R1 code after reset", int'({coarseCode, fineCode}), 0);
    chk("R1 done after reset", int'(convDone), 0);

    // R9 / R4 / R5: conversions over several sensor values
    foreach (tgts[i]) begin
      startConv(tgts[i], cyc);
      chk("R4 conversion length", cyc, 13);
      chk("R9 result vs sensor", int'(resultCode), expectResult(tgts[i]));
      chk("R5 result equals final code", int'(resultCode), int'({coarseCode, fineCode}));
      if (tgts[i] == 2731) begin
        // R8: 0x0AAA splits into coarse 0x5 and fine 0x0AA
        chk("R8 coarse slice", int'(coarseCode), 5);
        chk("R8 fine slice", int'(fineCode), 170);
      end
      @(negedge clk);
      chk("R5 done one cycle", int'(convDone), 0);
    end

    // R3: comparator forced to 1 keeps every trial bit
    cmpForce = 1'b1; cmpForceVal = 1'b1;
    target = 0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    @(negedge clk);
    chk("R3 keep bit12 arm bit11", int'({coarseCode, fineCode}), 'h1800);
    repeat (12) @(negedge clk);
    chk("R3 all kept", int'(resultCode), 'h1FFF);

    // R3: comparator forced to 0 clears every trial bit
    cmpForceVal = 1'b0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    @(negedge clk);
    chk("R3 clear bit12 arm bit11", int'({coarseCode, fineCode}), 'h0800);
    // R6: old result still held mid-search
    chk("R6 result held during search", int'(resultCode), 'h1FFF);
    repeat (12) @(negedge clk);
    chk("R3 all cleared", int'(resultCode), 0);
    cmpForce = 1'b0;

    // R7: second start in the middle of a search is ignored
    target = 3000;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cyc = 0;
    repeat (5) begin @(negedge clk); cyc++; end
    startPulse = 1'b1;
    @(negedge clk); cyc++;
    startPulse = 1'b0;
    while (!convDone && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R7 finish time unchanged", cyc, 13);
    chk("R7 result unchanged", int'(resultCode), 2999);

    // R10: comparator activity while idle has no effect
    repeat (2) @(negedge clk);
    saveCode = int'({coarseCode, fineCode});
    saveRes = int'(resultCode);
    cmpForce = 1'b1;
    for (int j = 0; j < 6; j++) begin
      cmpForceVal = j[0];
      @(negedge clk);
    end
    chk("R10 code idle", int'({coarseCode, fineCode}), saveCode);
    chk("R10 result idle", int'(resultCode), saveRes);
    cmpForce = 1'b0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule